// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sequences write and erase work on a small modelled nonvolatile array of 16-bit words that is divided into pages. Software sets mode bits and an address through a narrow register port. It then either issues a half-word write on the array port, or writes a start bit to erase one page or the whole array. While an operation runs, the block shows busy. When the operation ends, it leaves sticky completion and error flags in a status register.

Before a half-word write changes a location, the sequencer reads that location back. The write goes ahead only if the word is blank (0xFFFF) or if the data is 0x0000. The array is split into equal protection groups, and each group has one protection input bit. A protected target causes the operation to be dropped with a protection error. Program and erase each hold busy for a parameterised number of cycles, counted down in hardware. Erase also sweeps every word of the selected range at one word per cycle.

Top module: `nvm_seq`

## Requirements
- R1: After reset, busy is 0. The status register (reg_sel 2) and the control register (reg_sel 0) both read 0. Every array word reads 0xFFFF.
- R2: Program-enable is control bit 0. When it is set and the target word reads 0xFFFF, a pulse on arr_we stores arr_wdata at arr_addr. When busy falls, the done flag (status bit 1) is set.
- R3: While program-enable is 0, a pulse on arr_we has no effect. Busy stays 0 and the word is unchanged.
- R4: A program aimed at a word that is not 0xFFFF with nonzero data is dropped. The word keeps its value, the program-error flag (status bit 2) is set, and status bit 1 stays 0.
- R5: Programming the value 0x0000 always stores 0x0000 without raising the program-error flag, even when the word is not blank.
- R6: Input wp_grp[g] protects group g, which is the words whose top log2(PROT_W) address bits equal g. A program or page erase that touches a protected group is dropped. The protection-error flag (status bit 3) is set, the array is unchanged, and status bit 1 stays 0.
- R7: Page erase works as follows. Page-erase mode is control bit 1. The address register (reg_sel 1) holds any word address in the page, where a page is 2^PAGE_W words. Writing the control register with bit 1 and start bit 3 set makes that page read 0xFFFF. Other pages are untouched, status bit 1 is set, and start reads back as 0.
- R8: Mass erase is control bit 2 together with start. It sets every word to 0xFFFF. If any wp_grp bit is 1, the mass erase is instead dropped with the protection-error flag set.
- R9: Busy rises on the clock edge that accepts an operation. It stays high for at least PROG_CYC cycles for a program, and for at least 2^ADDR_W + ERASE_CYC cycles for a mass erase.
- R10: Register writes to any select while busy is 1 have no effect on the control, address or status contents.
- R11: Status bits 1 to 3 are sticky. Writing 1 to a bit at reg_sel 2 clears it, and writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register contents |
| arr_we | input | 1 | Half-word program strobe |
| arr_addr | input | ADDR_W | Array word address for program and read |
| arr_wdata | input | 16 | Half-word to program |
| arr_rdata | output | 16 | Array word, one cycle after arr_addr while idle |
| wp_grp | input | PROT_W | Per-group write protection |
| busy | output | 1 | Operation in progress |

## Verification
The assertions assume that wp_grp does not change while busy is high. The protection check is taken when an operation is accepted, and the guard on array writes compares against the live input. They also assume that arr_addr is only meaningful for reads while the block is idle. The bench changes wp_grp only between operations. It reads the array only after busy has fallen. It issues register writes during busy only to test that they are discarded.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam int BIT_PROG  = 0;
  localparam int BIT_PAGE  = 1;
  localparam int BIT_MASS  = 2;
  localparam int BIT_START = 3;

  localparam int BIT_BUSY  = 0;
  localparam int BIT_DONE  = 1;
  localparam int BIT_PGERR = 2;
  localparam int BIT_WPERR = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PG_RD, ST_PG_CHK, ST_SWEEP, ST_WAIT, ST_PG_WR, ST_END
  } seq_state_e;

  typedef enum logic [1:0] {OP_PROG, OP_PAGE, OP_MASS} seq_op_e;
endpackage

// File: rtl/nvm_seq_array.sv
module nvm_seq_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nvm_seq_regs.sv
module nvm_seq_regs
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic [1:0]               reg_sel,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic                     arr_we,
  input  logic                     busy,
  input  logic                     done,
  input  logic                     done_ok,
  input  logic                     done_pgerr,
  input  logic                     done_wperr,
  output logic                     go_prog,
  output logic                     go_page,
  output logic                     go_mass,
  output logic [ADDR_W-PAGE_W-1:0] page_idx
);
  logic [2:0]        ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic              eop_q, pgerr_q, wperr_q;
  logic              wr_ok, start;
  logic              unused_wdata;

  assign wr_ok    = reg_we && !busy;
  assign start    = wr_ok && reg_sel == SEL_CTRL && reg_wdata[BIT_START];
  assign go_mass  = start && reg_wdata[BIT_MASS];
  assign go_page  = start && reg_wdata[BIT_PAGE] && !reg_wdata[BIT_MASS];
  assign go_prog  = arr_we && ctrl_q[BIT_PROG] && !busy;
  assign page_idx = addr_q[ADDR_W-1:PAGE_W];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      addr_q <= '0;
    end else if (wr_ok) begin
      if (reg_sel == SEL_CTRL) ctrl_q <= reg_wdata[2:0];
      if (reg_sel == SEL_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eop_q   <= 1'b0;
      pgerr_q <= 1'b0;
      wperr_q <= 1'b0;
    end else if (done) begin
      eop_q   <= eop_q   | done_ok;
      pgerr_q <= pgerr_q | done_pgerr;
      wperr_q <= wperr_q | done_wperr;
    end else if (wr_ok && reg_sel == SEL_STAT) begin
      eop_q   <= eop_q   & ~reg_wdata[BIT_DONE];
      pgerr_q <= pgerr_q & ~reg_wdata[BIT_PGERR];
      wperr_q <= wperr_q & ~reg_wdata[BIT_WPERR];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: reg_rdata[2:0] = ctrl_q;
      SEL_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
      SEL_STAT: begin
        reg_rdata[BIT_BUSY]  = busy;
        reg_rdata[BIT_DONE]  = eop_q;
        reg_rdata[BIT_PGERR] = pgerr_q;
        reg_rdata[BIT_WPERR] = wperr_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R10: writes during an operation leave the registers alone
  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we) |=> ($stable(ctrl_q) && $stable(addr_q)));

  // R11: done flag only falls through a write-one clear
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (eop_q && !(wr_ok && reg_sel == SEL_STAT && reg_wdata[BIT_DONE])) |=> eop_q);

  // R2: a successful completion reaches the status register
  a_r2_done_flag_set: assert property (@(posedge clk) disable iff (rst)
    (done && done_ok) |=> eop_q);
endmodule

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
  import nvm_seq_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 16,
  parameter int          PAGE_W    = 4,
  parameter int          PROT_W    = 4,
  parameter int unsigned PROG_CYC  = 6,
  parameter int unsigned ERASE_CYC = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go_prog,
  input  logic                     go_page,
  input  logic                     go_mass,
  input  logic [ADDR_W-1:0]        prog_addr,
  input  logic [DATA_W-1:0]        prog_data,
  input  logic [ADDR_W-PAGE_W-1:0] page_idx,
  input  logic [PROT_W-1:0]        wp_grp,
  output logic [ADDR_W-1:0]        ram_addr,
  output logic                     ram_we,
  output logic [DATA_W-1:0]        ram_wdata,
  input  logic [DATA_W-1:0]        ram_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     done_ok,
  output logic                     done_pgerr,
  output logic                     done_wperr
);
  localparam int          PIDX_W  = ADDR_W - PAGE_W;
  localparam int          GRP_W   = $clog2(PROT_W);
  localparam int unsigned CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int          CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e        state;
  seq_op_e           op_q;
  logic [ADDR_W-1:0] tgt_q, last_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              res_ok, res_pg, res_wp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_q   <= OP_PROG;
      tgt_q  <= '0;
      last_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      res_ok <= 1'b0;
      res_pg <= 1'b0;
      res_wp <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          res_ok <= 1'b0;
          res_pg <= 1'b0;
          res_wp <= 1'b0;
          if (go_mass) begin
            op_q   <= OP_MASS;
            tgt_q  <= '0;
            last_q <= '1;
            if (|wp_grp) begin
              res_wp <= 1'b1;
              state  <= ST_END;
            end else state <= ST_SWEEP;
          end else if (go_page) begin
            op_q   <= OP_PAGE;
            tgt_q  <= {page_idx, {PAGE_W{1'b0}}};
            last_q <= {page_idx, {PAGE_W{1'b1}}};
            if (wp_grp[page_idx[PIDX_W-1 -: GRP_W]]) begin
              res_wp <= 1'b1;
              state  <= ST_END;
            end else state <= ST_SWEEP;
          end else if (go_prog) begin
            op_q   <= OP_PROG;
            tgt_q  <= prog_addr;
            data_q <= prog_data;
            if (wp_grp[prog_addr[ADDR_W-1 -: GRP_W]]) begin
              res_wp <= 1'b1;
              state  <= ST_END;
            end else state <= ST_PG_RD;
          end
        end
        ST_PG_RD: state <= ST_PG_CHK;
        ST_PG_CHK: begin
          if (data_q == '0 || ram_rdata == {DATA_W{1'b1}}) begin
            cnt_q <= CNT_W'(PROG_CYC);
            state <= ST_WAIT;
          end else begin
            res_pg <= 1'b1;
            state  <= ST_END;
          end
        end
        ST_SWEEP: begin
          if (tgt_q == last_q) begin
            cnt_q <= CNT_W'(ERASE_CYC);
            state <= ST_WAIT;
          end else tgt_q <= tgt_q + ADDR_W'(1);
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            if (op_q == OP_PROG) state <= ST_PG_WR;
            else begin
              res_ok <= 1'b1;
              state  <= ST_END;
            end
          end else cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_PG_WR: begin
          res_ok <= 1'b1;
          state  <= ST_END;
        end
        ST_END:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ram_addr   = tgt_q;
  assign ram_we     = (state == ST_SWEEP) || (state == ST_PG_WR);
  assign ram_wdata  = (state == ST_PG_WR) ? data_q : {DATA_W{1'b1}};
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_END);
  assign done_ok    = res_ok;
  assign done_pgerr = res_pg;
  assign done_wperr = res_wp;

  // R6: the array is never written inside a protected group
  a_r6_no_protected_write: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !wp_grp[ram_addr[ADDR_W-1 -: GRP_W]]);

  // R4: a failed blank check never reaches the array
  a_r4_dirty_target_skipped: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PG_CHK && data_q != '0 && ram_rdata != {DATA_W{1'b1}}) |=> !ram_we);

  // R9: the latency counter stays inside its loaded range
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (cnt_q <= CNT_W'(CNT_MAX)));

  // R9: busy only drops after a completion cycle
  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done));
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_seq_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          PAGE_W    = 4,
  parameter int          PROT_W    = 4,
  parameter int unsigned PROG_CYC  = 6,
  parameter int unsigned ERASE_CYC = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              arr_we,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [15:0]       arr_wdata,
  output logic [15:0]       arr_rdata,
  input  logic [PROT_W-1:0] wp_grp,
  output logic              busy
);
  localparam int DATA_W = 16;
  localparam int PIDX_W = ADDR_W - PAGE_W;

  logic              go_prog, go_page, go_mass;
  logic [PIDX_W-1:0] page_idx;
  logic              done, done_ok, done_pgerr, done_wperr;
  logic [ADDR_W-1:0] fsm_addr, ram_addr;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  nvm_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) i_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_we(arr_we),
    .busy(busy), .done(done), .done_ok(done_ok), .done_pgerr(done_pgerr),
    .done_wperr(done_wperr), .go_prog(go_prog), .go_page(go_page),
    .go_mass(go_mass), .page_idx(page_idx)
  );

  nvm_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PROT_W(PROT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) i_fsm (
    .clk(clk), .rst(rst), .go_prog(go_prog), .go_page(go_page),
    .go_mass(go_mass), .prog_addr(arr_addr), .prog_data(arr_wdata),
    .page_idx(page_idx), .wp_grp(wp_grp), .ram_addr(fsm_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .busy(busy), .done(done), .done_ok(done_ok), .done_pgerr(done_pgerr),
    .done_wperr(done_wperr)
  );

  assign ram_addr = busy ? fsm_addr : arr_addr;

  nvm_seq_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  assign arr_rdata = ram_rdata;
endmodule

// File: tb/test_nvm_seq.sv
module test_nvm_seq;
  localparam int ADDR_W    = 8;
  localparam int PAGE_W    = 4;
  localparam int PROT_W    = 4;
  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_sel = '0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic              arr_we = 1'b0;
  logic [ADDR_W-1:0] arr_addr = '0;
  logic [15:0]       arr_wdata = '0;
  logic [15:0]       arr_rdata;
  logic [PROT_W-1:0] wp_grp = '0;
  logic              busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  nvm_seq #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROT_W(PROT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) i_nvm_seq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
    .wp_grp(wp_grp), .busy(busy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lo);
    checks++;
    if (act < lo) begin
      fails++;
      $display("FAIL %s act=%0d exp>=%0d", req, act, lo);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic wr_arr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    arr_we = 1'b1; arr_addr = a; arr_wdata = d;
    @(negedge clk);
    arr_we = 1'b0;
  endtask

  task automatic rd_arr(input logic [ADDR_W-1:0] a, output logic [15:0] d);
    @(negedge clk);
    arr_addr = a;
    @(negedge clk);
    d = arr_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd_reg(2'd2, v); chk("R1 status after reset", v, 16'h0000);
    rd_reg(2'd0, v); chk("R1 control after reset", v, 16'h0000);
    chk("R1 busy after reset", {15'd0, busy}, 16'h0000);
    rd_arr(8'h00, v); chk("R1 array word 0 blank", v, 16'hFFFF);
    rd_arr(8'hFF, v); chk("R1 array last word blank", v, 16'hFFFF);
  endtask

  task automatic t_program;
    logic [15:0] v; int n;
    wr_reg(2'd0, 16'h0001);
    wr_arr(8'h10, 16'h1234);
    chk("R9 busy after program accepted", {15'd0, busy}, 16'h0001);
    wait_idle(n);
    chk_ge("R9 program busy length", n, PROG_CYC);
    rd_reg(2'd2, v); chk("R2 done flag after program", v, 16'h0002);
    rd_arr(8'h10, v); chk("R2 programmed word", v, 16'h1234);
    wr_reg(2'd2, 16'h0002);
    rd_reg(2'd2, v); chk("R11 done cleared by write one", v, 16'h0000);
  endtask

  task automatic t_prog_disabled;
    logic [15:0] v;
    wr_reg(2'd0, 16'h0000);
    wr_arr(8'h20, 16'h5555);
    chk("R3 no busy without program enable", {15'd0, busy}, 16'h0000);
    rd_arr(8'h20, v); chk("R3 word untouched", v, 16'hFFFF);
    rd_reg(2'd2, v); chk("R3 status untouched", v, 16'h0000);
  endtask

  task automatic t_dirty;
    logic [15:0] v; int n;
    wr_reg(2'd0, 16'h0001);
    wr_arr(8'h10, 16'hABCD);
    wait_idle(n);
    rd_reg(2'd2, v); chk("R4 program error only", v, 16'h0004);
    rd_arr(8'h10, v); chk("R4 dirty word kept", v, 16'h1234);
    wr_reg(2'd2, 16'h0000);
    rd_reg(2'd2, v); chk("R11 writing zero keeps error", v, 16'h0004);
    wr_reg(2'd2, 16'h0004);
    rd_reg(2'd2, v); chk("R11 error cleared", v, 16'h0000);
  endtask

  task automatic t_zero;
    logic [15:0] v; int n;
    wr_arr(8'h10, 16'h0000);
    wait_idle(n);
    rd_reg(2'd2, v); chk("R5 zero write no error", v, 16'h0002);
    rd_arr(8'h10, v); chk("R5 word now zero", v, 16'h0000);
    wr_reg(2'd2, 16'h000E);
  endtask

  task automatic t_protect_prog;
    logic [15:0] v; int n;
    wr_arr(8'h45, 16'h00C5);
    wait_idle(n);
    wr_reg(2'd2, 16'h000E);
    wp_grp = 4'b0010;
    wr_arr(8'h50, 16'h1111);
    wait_idle(n);
    rd_reg(2'd2, v); chk("R6 protect error on program", v, 16'h0008);
    rd_arr(8'h50, v); chk("R6 protected word blank", v, 16'hFFFF);
    wr_reg(2'd2, 16'h0008);
  endtask

  task automatic t_page_erase;
    logic [15:0] v; int n;
    wr_arr(8'h21, 16'h00AA); wait_idle(n);
    wr_arr(8'h31, 16'h00BB); wait_idle(n);
    wr_reg(2'd2, 16'h000E);
    wr_reg(2'd1, 16'h0027);
    wr_reg(2'd0, 16'h0002);
    wr_reg(2'd0, 16'h000A);
    wait_idle(n);
    rd_reg(2'd0, v); chk("R7 start bit reads zero", v, 16'h0002);
    rd_reg(2'd2, v); chk("R7 done after page erase", v, 16'h0002);
    rd_arr(8'h21, v); chk("R7 page word erased", v, 16'hFFFF);
    rd_arr(8'h31, v); chk("R7 next page untouched", v, 16'h00BB);
    rd_arr(8'h10, v); chk("R7 previous page untouched", v, 16'h0000);
    wr_reg(2'd2, 16'h000E);
    wr_reg(2'd1, 16'h0040);
    wr_reg(2'd0, 16'h000A);
    wait_idle(n);
    rd_reg(2'd2, v); chk("R6 protect error on page erase", v, 16'h0008);
    rd_arr(8'h45, v); chk("R6 protected page kept", v, 16'h00C5);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] v; int n;
    wp_grp = 4'b0000;
    wr_reg(2'd0, 16'h000A);
    wr_reg(2'd2, 16'h0008);
    wr_reg(2'd1, 16'h0099);
    wr_reg(2'd0, 16'h0004);
    wait_idle(n);
    rd_reg(2'd1, v); chk("R10 address kept", v, 16'h0040);
    rd_reg(2'd0, v); chk("R10 control kept", v, 16'h0002);
    rd_reg(2'd2, v); chk("R10 error flag not cleared", v, 16'h000A);
    rd_arr(8'h45, v); chk("R7 unprotected page erased", v, 16'hFFFF);
    wr_reg(2'd2, 16'h000E);
  endtask

  task automatic t_mass;
    logic [15:0] v; int n;
    wr_reg(2'd0, 16'h0001);
    wr_arr(8'hF3, 16'h0F0F); wait_idle(n);
    wr_reg(2'd2, 16'h000E);
    wp_grp = 4'b0001;
    wr_reg(2'd0, 16'h000C);
    wait_idle(n);
    rd_reg(2'd2, v); chk("R8 mass erase blocked", v, 16'h0008);
    rd_arr(8'h10, v); chk("R8 blocked erase keeps data", v, 16'h0000);
    wr_reg(2'd2, 16'h0008);
    wp_grp = 4'b0000;
    wr_reg(2'd0, 16'h000C);
    wait_idle(n);
    chk_ge("R9 mass erase busy length", n, (1 << ADDR_W) + ERASE_CYC);
    rd_reg(2'd2, v); chk("R8 done after mass erase", v, 16'h0002);
    rd_arr(8'h10, v); chk("R8 low word erased", v, 16'hFFFF);
    rd_arr(8'h31, v); chk("R8 middle word erased", v, 16'hFFFF);
    rd_arr(8'hF3, v); chk("R8 high word erased", v, 16'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_prog_disabled();
    t_dirty();
    t_zero();
    t_protect_prog();
    t_page_erase();
    t_busy_ignore();
    t_mass();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule